// File: doc/BRIEF.md
# Byte-lane dual-port memory

This block is a clocked two-port word memory whose default size is 4096 words of 16 bits. Each port has its own address, its own write data and read data, and its own set of active-high controls: a select, a write strobe, an output gate, and one select for each byte lane. Both ports work independently and may reach any word in the same cycle, including the same word. A write lands at the clock edge. Read data and per-lane valid flags appear one cycle after the request.

Each port decodes its controls into one of four named modes. The modes are chosen in priority order:
- MODE_IDLE: the select is low, or both lane selects are low.
- MODE_WRITE: the write strobe is high.
- MODE_MUTED: a read is requested while the output gate is low.
- MODE_READ: every other case.

The mode register of each port holds the lanes that are driving. Its transitions are fixed: any mode moves to the driving state for the lanes read in MODE_READ, and moves to the all-quiet state from MODE_IDLE, MODE_WRITE and MODE_MUTED.

There is no tri-state bus. A lane that is not driving reads as zero, and its valid bit is low.

Top module: `dpm_dual_port`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits, by default 4096 x 16 with a 12-bit address. Either port can write any word, including the highest address, and either port can read it back.
- R2: A read request sampled at a clock edge shows its data and valid bits just after that same edge. No output changes before that edge.
- R3: With the select (cs) low, the port writes nothing, its rvalid is 2'b00 and its rdata is 0 from the next edge on.
- R4: With cs high but both lane selects (hi, lo) low, the port neither writes nor reads. Its rvalid is 2'b00.
- R5: A write (cs=1, wr=1) updates only the lanes whose selects are high. hi owns bits 15:8 and lo owns bits 7:0.
- R6: A read (cs=1, wr=0, oe=1) sets rvalid[1] to hi and rvalid[0] to lo. A lane whose valid bit is low reads as 0.
- R7: With oe low, a read gives rvalid 2'b00 and rdata 0. A write with oe low still updates the array.
- R8: When both ports write the same word in one cycle, each lane is resolved on its own, and port A (the left port) wins any lane that both ports write.
- R9: A read of a word that the other port writes in the same cycle returns the contents from before that write.
- R10: During reset, and on the first edge after it, rvalid and rdata of both ports are 0.
- R11: The two ports can access different words in the same cycle, and each port returns its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read stages |
| a_cs | input | 1 | Port A select |
| a_wr | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_oe | input | 1 | Port A output gate |
| a_hi | input | 1 | Port A upper lane select (bits 15:8) |
| a_lo | input | 1 | Port A lower lane select (bits 7:0) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, unselected lanes zero |
| a_rvalid | output | 2 | Port A per-lane valid, [1]=upper, [0]=lower |
| b_cs | input | 1 | Port B select |
| b_wr | input | 1 | Port B write strobe |
| b_oe | input | 1 | Port B output gate |
| b_hi | input | 1 | Port B upper lane select |
| b_lo | input | 1 | Port B lower lane select |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data |
| b_rvalid | output | 2 | Port B per-lane valid |

## Verification
The bench builds the block with ADDR_W=6 and the default 16-bit word of two 8-bit lanes. The 64-word array keeps every address reachable. This brings the top word (63) into the test set next to low addresses. Same-word collisions between the ports, lane-by-lane masking, and the old-data rule on read-during-write are all exercised on this full byte-lane layout.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_READ  = 2'd2,
        MODE_MUTED = 2'd3
    } port_mode_e;

endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
    import dpm_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             cs,
    input  logic             wr,
    input  logic             oe,
    input  logic [LANES-1:0] lane_sel,
    output logic [LANES-1:0] wr_lanes,
    output logic [LANES-1:0] rd_lanes
);

    port_mode_e mode;

    // Mode pick, highest priority first
    always_comb begin
        if (!cs || lane_sel == '0) begin
            mode = MODE_IDLE;
        end else if (wr) begin
            mode = MODE_WRITE;
        end else if (!oe) begin
            mode = MODE_MUTED;
        end else begin
            mode = MODE_READ;
        end
    end

    // Lane strobes per mode
    always_comb begin
        wr_lanes = '0;
        rd_lanes = '0;
        unique case (mode)
            MODE_WRITE: wr_lanes = lane_sel;
            MODE_READ:  rd_lanes = lane_sel;
            MODE_IDLE, MODE_MUTED: begin
                wr_lanes = '0;
                rd_lanes = '0;
            end
            default: begin
                wr_lanes = '0;
                rd_lanes = '0;
            end
        endcase
    end

    // Decode must never write and read at once (R5, R6)
    always_comb begin
        a_no_mixed_r5: assert ((wr_lanes & rd_lanes) == '0);
    end

endmodule

// File: rtl/dpm_lane_array.sv
module dpm_lane_array #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       a_addr,
    input  logic [LANES*LANE_W-1:0] a_wdata,
    input  logic [LANES-1:0]        a_we,
    input  logic [ADDR_W-1:0]       b_addr,
    input  logic [LANES*LANE_W-1:0] b_wdata,
    input  logic [LANES-1:0]        b_we,
    output logic [LANES*LANE_W-1:0] a_q,
    output logic [LANES*LANE_W-1:0] b_q
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Port B first, port A second: A wins a lane both ports write (R8).
    // Reads see the contents from before this edge (R9).
    always_ff @(posedge clk) begin
        for (int ln = 0; ln < LANES; ln++) begin
            if (b_we[ln]) mem[b_addr][ln*LANE_W +: LANE_W] <= b_wdata[ln*LANE_W +: LANE_W];
            if (a_we[ln]) mem[a_addr][ln*LANE_W +: LANE_W] <= a_wdata[ln*LANE_W +: LANE_W];
        end
        a_q <= mem[a_addr];
        b_q <= mem[b_addr];
    end

endmodule

// File: rtl/dpm_read_stage.sv
module dpm_read_stage #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        rd_lanes,
    input  logic [LANES*LANE_W-1:0] word_q,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic [LANES-1:0]        rvalid
);

    logic [LANES-1:0] drive_q;

    // State register: lanes that drive in this cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '0;
        end else begin
            drive_q <= rd_lanes;
        end
    end

    // Outputs: a lane that is not driving reads as zero
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = drive_q[g] ? word_q[g*LANE_W +: LANE_W] : '0;
    end
    assign rvalid = drive_q;

    p_follow_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rvalid == $past(rd_lanes));

endmodule

// File: rtl/dpm_dual_port.sv
module dpm_dual_port #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      a_cs,
    input  logic                      a_wr,
    input  logic                      a_oe,
    input  logic                      a_hi,
    input  logic                      a_lo,
    input  logic [ADDR_W-1:0]         a_addr,
    input  logic [DATA_W-1:0]         a_wdata,
    output logic [DATA_W-1:0]         a_rdata,
    output logic [DATA_W/LANE_W-1:0]  a_rvalid,
    input  logic                      b_cs,
    input  logic                      b_wr,
    input  logic                      b_oe,
    input  logic                      b_hi,
    input  logic                      b_lo,
    input  logic [ADDR_W-1:0]         b_addr,
    input  logic [DATA_W-1:0]         b_wdata,
    output logic [DATA_W-1:0]         b_rdata,
    output logic [DATA_W/LANE_W-1:0]  b_rvalid
);

    localparam int LANES = DATA_W / LANE_W;

    logic [LANES-1:0]  a_sel, b_sel;
    logic [LANES-1:0]  a_we, b_we, a_re, b_re;
    logic [DATA_W-1:0] a_word, b_word;

    // Lane select vectors: upper select on the top lane, lower on lane 0
    always_comb begin
        a_sel = '0;
        b_sel = '0;
        a_sel[LANES-1] = a_hi;
        a_sel[0]       = a_lo;
        b_sel[LANES-1] = b_hi;
        b_sel[0]       = b_lo;
    end

    dpm_port_decode #(.LANES(LANES)) u_dec_a (
        .cs(a_cs), .wr(a_wr), .oe(a_oe), .lane_sel(a_sel),
        .wr_lanes(a_we), .rd_lanes(a_re)
    );

    dpm_port_decode #(.LANES(LANES)) u_dec_b (
        .cs(b_cs), .wr(b_wr), .oe(b_oe), .lane_sel(b_sel),
        .wr_lanes(b_we), .rd_lanes(b_re)
    );

    dpm_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we),
        .a_q(a_word), .b_q(b_word)
    );

    dpm_read_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .rd_lanes(a_re), .word_q(a_word),
        .rdata(a_rdata), .rvalid(a_rvalid)
    );

    dpm_read_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .rd_lanes(b_re), .word_q(b_word),
        .rdata(b_rdata), .rvalid(b_rvalid)
    );

    p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !a_cs |=> (a_rvalid == '0 && a_rdata == '0));

    p_no_lane_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_hi && !b_lo) |=> b_rvalid == '0);

    p_lane_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cs && !a_wr && a_oe) |=> a_rvalid == $past(a_sel));

    p_gate_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !b_oe |=> (b_rvalid == '0 && b_rdata == '0));

    p_write_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_cs && a_wr) |=> a_rvalid == '0);

endmodule

// File: tb/test_dpm_dual_port.sv
`timescale 1ns/100ps
module test_dpm_dual_port;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int VW = 1 + 5 + AW + DW + 2 + DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_cs = 0, a_wr = 0, a_oe = 0, a_hi = 0, a_lo = 0;
    logic          b_cs = 0, b_wr = 0, b_oe = 0, b_hi = 0, b_lo = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rdata, b_rdata;
    logic [1:0]    a_rvalid, b_rvalid;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dpm_dual_port #(.ADDR_W(AW), .DATA_W(DW), .LANE_W(8)) i_dpm_dual_port (
        .clk(clk), .rst_n(rst_n),
        .a_cs(a_cs), .a_wr(a_wr), .a_oe(a_oe), .a_hi(a_hi), .a_lo(a_lo),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_cs(b_cs), .b_wr(b_wr), .b_oe(b_oe), .b_hi(b_hi), .b_lo(b_lo),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    // Vector: port(0=A,1=B), {cs,wr,oe,hi,lo}, addr, wdata, expected rvalid, expected rdata
    localparam logic [VW-1:0] VEC [15] = '{
        {1'b0, 5'b11011, 6'd5,  16'h1234, 2'b00, 16'h0000},  // R5 write both
        {1'b0, 5'b10111, 6'd5,  16'h0000, 2'b11, 16'h1234},  // R1 read back
        {1'b0, 5'b11010, 6'd5,  16'hABCD, 2'b00, 16'h0000},  // R5 upper only
        {1'b0, 5'b10111, 6'd5,  16'h0000, 2'b11, 16'hAB34},  // R5
        {1'b0, 5'b11001, 6'd5,  16'h99EF, 2'b00, 16'h0000},  // R5 lower only
        {1'b1, 5'b10111, 6'd5,  16'h0000, 2'b11, 16'hABEF},  // R1 other port
        {1'b1, 5'b10110, 6'd5,  16'h0000, 2'b10, 16'hAB00},  // R6 upper lane
        {1'b0, 5'b10101, 6'd5,  16'h0000, 2'b01, 16'h00EF},  // R6 lower lane
        {1'b0, 5'b10011, 6'd5,  16'h0000, 2'b00, 16'h0000},  // R7 gate low
        {1'b0, 5'b01011, 6'd5,  16'hFFFF, 2'b00, 16'h0000},  // R3 write deselected
        {1'b0, 5'b00111, 6'd5,  16'h0000, 2'b00, 16'h0000},  // R3 read deselected
        {1'b0, 5'b11000, 6'd5,  16'h0000, 2'b00, 16'h0000},  // R4 no lanes, write
        {1'b0, 5'b10111, 6'd5,  16'h0000, 2'b11, 16'hABEF},  // R3 R4 unchanged
        {1'b0, 5'b11011, 6'd63, 16'h5555, 2'b00, 16'h0000},  // R7 write with gate low
        {1'b1, 5'b10111, 6'd63, 16'h0000, 2'b11, 16'h5555}   // R1 top word
    };

    task automatic check(input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        {a_cs, a_wr, a_oe, a_hi, a_lo} = 5'b0;
        {b_cs, b_wr, b_oe, b_hi, b_lo} = 5'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic port_a(input logic [4:0] c, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        {a_cs, a_wr, a_oe, a_hi, a_lo} = c;
        a_addr = ad;
        a_wdata = d;
    endtask

    task automatic port_b(input logic [4:0] c, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        {b_cs, b_wr, b_oe, b_hi, b_lo} = c;
        b_addr = ad;
        b_wdata = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: outputs quiet in reset, with requests pending
        port_a(5'b10111, 6'd1, 16'h0);
        port_b(5'b10111, 6'd2, 16'h0);
        step();
        check("R10", {a_rvalid, a_rdata}, '0);
        check("R10", {b_rvalid, b_rdata}, '0);
        idle_all();
        rst_n = 1'b1;
        step();
        check("R10", {a_rvalid, a_rdata, b_rvalid, b_rdata} == '0 ? 18'h0 : 18'h1, 18'h0);

        for (int i = 0; i < 15; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            idle_all();
            if (v[VW-1]) port_b(v[VW-2 -: 5], v[VW-7 -: AW], v[DW+18-1 -: DW]);
            else         port_a(v[VW-2 -: 5], v[VW-7 -: AW], v[DW+18-1 -: DW]);
            step();
            if (v[VW-1]) check($sformatf("R1-R7 vector %0d", i), {b_rvalid, b_rdata}, v[DW+1:0]);
            else         check($sformatf("R1-R7 vector %0d", i), {a_rvalid, a_rdata}, v[DW+1:0]);
        end

        // R8: both write the same word, all lanes
        idle_all();
        port_a(5'b11011, 6'd10, 16'h1111);
        port_b(5'b11011, 6'd10, 16'h2222);
        step();
        idle_all();
        port_b(5'b10111, 6'd10, 16'h0);
        step();
        check("R8 full collision", {b_rvalid, b_rdata}, {2'b11, 16'h1111});

        // R8: A upper only, B both lanes
        idle_all();
        port_a(5'b11010, 6'd11, 16'hAAAA);
        port_b(5'b11011, 6'd11, 16'hBBBB);
        step();
        idle_all();
        port_a(5'b10111, 6'd11, 16'h0);
        step();
        check("R8 per-lane", {a_rvalid, a_rdata}, {2'b11, 16'hAABB});

        // R9: read during write from the other port returns old data
        idle_all();
        port_a(5'b11011, 6'd12, 16'h7777);
        step();
        port_a(5'b11011, 6'd12, 16'h8888);
        port_b(5'b10111, 6'd12, 16'h0);
        step();
        check("R9 old data", {b_rvalid, b_rdata}, {2'b11, 16'h7777});
        idle_all();
        port_b(5'b10111, 6'd12, 16'h0);
        step();
        check("R9 new data after", {b_rvalid, b_rdata}, {2'b11, 16'h8888});

        // R11: both ports read different words together
        idle_all();
        port_a(5'b10111, 6'd5, 16'h0);
        port_b(5'b10111, 6'd63, 16'h0);
        step();
        check("R11 port A", {a_rvalid, a_rdata}, {2'b11, 16'hABEF});
        check("R11 port B", {b_rvalid, b_rdata}, {2'b11, 16'h5555});

        // R2: no change before the edge, result right after it
        idle_all();
        step();
        port_a(5'b10111, 6'd12, 16'h0);
        #1;
        check("R2 before edge", {a_rvalid, a_rdata}, '0);
        step();
        check("R2 after edge", {a_rvalid, a_rdata}, {2'b11, 16'h8888});
        idle_all();
        step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule